// File: doc/BRIEF.md
# Fused Multiply-Add Double-Width Unit

This unit takes three unsigned 64-bit operands, forms the full 128-bit product of the first two, and adds the third operand to that product. The third operand is zero-extended and is not shifted. The 128-bit sum is returned as two 64-bit halves. The low half is the result limb and goes to the primary destination register. The high half is the carry limb and goes to an implicit second destination, whose register number is the primary number plus one.

The unit is the inner step of big-integer multiply and divide loops. A scalar is multiplied across a long vector of limbs, and each high half is fed back as the next addend. The full sum can never exceed 128 bits, because (2^64-1)^2 + (2^64-1) is less than 2^128, so no carry-out is produced.

Operands arrive through a valid/ready handshake. The multiplier is iterative: it retires one 16-bit digit of the second operand per cycle. The unit holds one operation at a time. A result stays on the outputs until the consumer takes it.

Top module: `limb_muladd`

## Requirements
- R1: After an operation with operands opA, opB, opC, the pair {resHi, resLo} equals opA*opB + opC, computed exactly as a 128-bit unsigned value.
- R2: opC is treated as unsigned and zero-extended. An addend with bit 63 set adds its full unsigned value, and all-ones operands give resHi = 64'hFFFF_FFFF_FFFF_FFFF and resLo = 0.
- R3: resLo carries bits 63:0 of the sum and resHi carries bits 127:64. resLo is tagged with loDst and resHi with hiDst.
- R4: loDst equals the dstIdx given with the operation. hiDst equals dstIdx + 1 modulo 32, so dstIdx 31 gives hiDst 0.
- R5: An operation is executed only when opSel equals 6'b110010. An operation with any other opSel value is still consumed on the handshake, but it produces no result: inReady is high again on the next cycle and outValid stays low.
- R6: An operation is accepted only on a clock edge where inValid and inReady are both high. inReady stays low from acceptance until the result has been taken.
- R7: While outValid is high and outReady is low, outValid, resLo, resHi, loDst and hiDst do not change.
- R8: outValid rises exactly 4 clock edges after the accepting edge. After the edge where outValid and outReady are both high, outValid is low and inReady is high.
- R9: During and right after reset, inReady is high and outValid is low.
- R10: Each result carries the operands and destination latched at acceptance. Input changes after acceptance do not alter it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operation offered |
| inReady | output | 1 | Unit can accept an operation |
| opSel | input | 6 | Extended opcode of the offered operation |
| opA | input | 64 | Multiplicand |
| opB | input | 64 | Multiplier |
| opC | input | 64 | Addend, zero-extended |
| dstIdx | input | 5 | Primary destination register index |
| outValid | output | 1 | Result available |
| outReady | input | 1 | Consumer takes the result |
| resLo | output | 64 | Low half of the sum |
| resHi | output | 64 | High half of the sum (carry limb) |
| loDst | output | 5 | Destination index for resLo |
| hiDst | output | 5 | Destination index for resHi |

## Verification
A result is due exactly four edges after the accepting edge, one edge per 16-bit digit. The bench drives inputs and samples outputs on falling edges. It counts the falling edges from acceptance until outValid appears and requires that count to be 4 before it compares any data. While it withholds outReady for a set number of cycles, it samples the result once per cycle. A discarded opcode must leave outValid low for six cycles, which is longer than the normal latency. On the falling edge after the release handshake, the bench checks that outValid is low and inReady is high.

// File: rtl/limb_muladd_pkg.sv
package limb_muladd_pkg;
  typedef struct packed {
    logic load;
    logic step;
  } dpCtrl_t;

  localparam int OP_W = 6;
  localparam logic [OP_W-1:0] MADD_XO = 6'b110010;
endpackage

// File: rtl/limb_muladd_ctrl.sv
module limb_muladd_ctrl
  import limb_muladd_pkg::*;
#(
  parameter int NUM_STEPS = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            inValid,
  input  logic [OP_W-1:0] opSel,
  input  logic            outReady,
  output logic            inReady,
  output logic            outValid,
  output dpCtrl_t         ctl
);
  localparam int CNT_W = $clog2(NUM_STEPS + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_DONE} state_t;

  state_t     state;
  logic [CNT_W-1:0] stepCnt;

  always_comb begin
    inReady  = (state == ST_IDLE);
    outValid = (state == ST_DONE);
    ctl.load = inValid && inReady && (opSel == MADD_XO);
    ctl.step = (state == ST_BUSY);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (ctl.load) begin
            state   <= ST_BUSY;
            stepCnt <= '0;
          end
        end
        ST_BUSY: begin
          stepCnt <= stepCnt + CNT_W'(1);
          if (stepCnt == CNT_W'(NUM_STEPS - 1)) state <= ST_DONE;
        end
        ST_DONE: begin
          if (outReady) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/limb_muladd_dp.sv
module limb_muladd_dp
  import limb_muladd_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int DIGIT_W = 16,
  parameter int IDX_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpCtrl_t           ctl,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] opC,
  input  logic [IDX_W-1:0]  dstIdx,
  output logic [DATA_W-1:0] resLo,
  output logic [DATA_W-1:0] resHi,
  output logic [IDX_W-1:0]  loDst,
  output logic [IDX_W-1:0]  hiDst
);
  localparam int WIDE_W = 2 * DATA_W;

  logic [WIDE_W-1:0] mcand;
  logic [WIDE_W-1:0] acc;
  logic [WIDE_W-1:0] partial;
  logic [DATA_W-1:0] mplier;
  logic [IDX_W-1:0]  dstReg;

  // One digit of the multiplier times the aligned multiplicand.
  always_comb begin
    partial = mcand * WIDE_W'(mplier[DIGIT_W-1:0]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mcand  <= '0;
      acc    <= '0;
      mplier <= '0;
      dstReg <= '0;
    end else if (ctl.load) begin
      mcand  <= {{DATA_W{1'b0}}, opA};
      acc    <= {{DATA_W{1'b0}}, opC};
      mplier <= opB;
      dstReg <= dstIdx;
    end else if (ctl.step) begin
      acc    <= acc + partial;
      mcand  <= mcand << DIGIT_W;
      mplier <= mplier >> DIGIT_W;
    end
  end

  assign resLo = acc[DATA_W-1:0];
  assign resHi = acc[WIDE_W-1:DATA_W];
  assign loDst = dstReg;
  assign hiDst = dstReg + IDX_W'(1);
endmodule

// File: rtl/limb_muladd.sv
module limb_muladd
  import limb_muladd_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int DIGIT_W = 16,
  parameter int IDX_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  output logic              inReady,
  input  logic [OP_W-1:0]   opSel,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] opC,
  input  logic [IDX_W-1:0]  dstIdx,
  output logic              outValid,
  input  logic              outReady,
  output logic [DATA_W-1:0] resLo,
  output logic [DATA_W-1:0] resHi,
  output logic [IDX_W-1:0]  loDst,
  output logic [IDX_W-1:0]  hiDst
);
  localparam int NUM_STEPS = DATA_W / DIGIT_W;

  dpCtrl_t ctl;

  limb_muladd_ctrl #(.NUM_STEPS(NUM_STEPS)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .opSel    (opSel),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .ctl      (ctl)
  );

  limb_muladd_dp #(.DATA_W(DATA_W), .DIGIT_W(DIGIT_W), .IDX_W(IDX_W)) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctl    (ctl),
    .opA    (opA),
    .opB    (opB),
    .opC    (opC),
    .dstIdx (dstIdx),
    .resLo  (resLo),
    .resHi  (resHi),
    .loDst  (loDst),
    .hiDst  (hiDst)
  );
endmodule

// File: rtl/limb_muladd_chk.sv
module limb_muladd_chk
  import limb_muladd_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int DIGIT_W = 16,
  parameter int IDX_W   = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              inValid,
  input logic              inReady,
  input logic [OP_W-1:0]   opSel,
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic [DATA_W-1:0] opC,
  input logic [IDX_W-1:0]  dstIdx,
  input logic              outValid,
  input logic              outReady,
  input logic [DATA_W-1:0] resLo,
  input logic [DATA_W-1:0] resHi,
  input logic [IDX_W-1:0]  loDst,
  input logic [IDX_W-1:0]  hiDst
);
  localparam int WIDE_W    = 2 * DATA_W;
  localparam int NUM_STEPS = DATA_W / DIGIT_W;
  localparam int LAT_W     = $clog2(NUM_STEPS + 2) + 1;

  logic              accept;
  logic              goodAcc;
  logic [WIDE_W-1:0] expSum;
  logic [IDX_W-1:0]  expDst;
  logic [LAT_W-1:0]  lat;

  assign accept  = inValid && inReady;
  assign goodAcc = accept && (opSel == MADD_XO);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      expSum <= '0;
      expDst <= '0;
      lat    <= '0;
    end else if (goodAcc) begin
      expSum <= ({{DATA_W{1'b0}}, opA} * {{DATA_W{1'b0}}, opB}) + {{DATA_W{1'b0}}, opC};
      expDst <= dstIdx;
      lat    <= '0;
    end else if (!outValid && lat < LAT_W'(NUM_STEPS + 1)) begin
      lat <= lat + LAT_W'(1);
    end
  end

  AST_SUM_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> ({resHi, resLo} == expSum)); // R1
  AST_DST_TAGS: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> (loDst == expDst && hiDst == expDst + IDX_W'(1))); // R4
  AST_NO_ACCEPT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> !inReady); // R6
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |=> (outValid && $stable(resLo) && $stable(resHi)
                                 && $stable(loDst) && $stable(hiDst))); // R7
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(outValid) |-> (lat == LAT_W'(NUM_STEPS))); // R8
  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && outReady) |=> (!outValid && inReady)); // R8
  AST_DROP_BAD_OP: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && opSel != MADD_XO) |=> (inReady && !outValid)); // R5
endmodule

bind limb_muladd limb_muladd_chk #(.DATA_W(DATA_W), .DIGIT_W(DIGIT_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .inValid(inValid), .inReady(inReady), .opSel(opSel),
  .opA(opA), .opB(opB), .opC(opC), .dstIdx(dstIdx), .outValid(outValid),
  .outReady(outReady), .resLo(resLo), .resHi(resHi), .loDst(loDst), .hiDst(hiDst)
);

// File: tb/limb_muladd_bench.sv
module limb_muladd_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_STEPS  = 4;
  localparam int WATCHDOG   = 20000;
  localparam logic [5:0] XO_OK = 6'b110010;
  localparam int NVEC = 8;

  localparam logic [63:0] TAB_A [NVEC] = '{64'd0, 64'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_DEF0,
                                           64'h8000_0000_0000_0000, 64'd1, 64'hDEAD_BEEF_0000_FFFF, 64'h0000_0001_0000_0000};
  localparam logic [63:0] TAB_B [NVEC] = '{64'd12345, 64'd7, 64'd2, 64'h0FED_CBA9_8765_4321,
                                           64'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'hCAFE_F00D_1234_5678, 64'h0000_0001_0000_0000};
  localparam logic [63:0] TAB_C [NVEC] = '{64'd99, 64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0001,
                                           64'd0, 64'd1, 64'h7777_0000_3333_1111, 64'd5};
  localparam logic [4:0]  TAB_D [NVEC] = '{5'd0, 5'd1, 5'd31, 5'd10, 5'd30, 5'd17, 5'd2, 5'd31};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [5:0]  opSel = '0;
  logic [63:0] opA = '0, opB = '0, opC = '0;
  logic [4:0]  dstIdx = '0;
  logic        outValid;
  logic        outReady = 1'b0;
  logic [63:0] resLo, resHi;
  logic [4:0]  loDst, hiDst;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  limb_muladd u_limb_muladd (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inReady(inReady), .opSel(opSel),
    .opA(opA), .opB(opB), .opC(opC), .dstIdx(dstIdx), .outValid(outValid),
    .outReady(outReady), .resLo(resLo), .resHi(resHi), .loDst(loDst), .hiDst(hiDst)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic doOp(input logic [63:0] a, input logic [63:0] b, input logic [63:0] c,
                      input logic [4:0] dst, input int holdCycles, input bit pushExtra,
                      output logic [63:0] lo, output logic [63:0] hi);
    logic [127:0] exp;
    int lat;
    exp = ({64'd0, a} * {64'd0, b}) + {64'd0, c};
    @(negedge clk);
    check(inReady, "R6", "idle inReady", 128'(inReady), 128'd1);
    opA = a; opB = b; opC = c; dstIdx = dst; opSel = XO_OK; inValid = 1'b1;
    @(negedge clk);
    inValid = pushExtra;
    opA = ~a; opB = ~b; opC = ~c; dstIdx = ~dst;  // R10: scramble after acceptance
    lat = 0;
    while (!outValid && lat < 20) begin
      check(!inReady, "R6", "busy inReady", 128'(inReady), 128'd0);
      @(negedge clk);
      lat++;
    end
    check(lat == NUM_STEPS, "R8", "latency", 128'(lat), 128'(NUM_STEPS));
    lo = resLo; hi = resHi;
    check({resHi, resLo} == exp, "R1", "sum", {resHi, resLo}, exp);
    check(resLo == exp[63:0] && loDst == dst, "R3", "low half and tag",
          {59'd0, loDst, resLo}, {59'd0, dst, exp[63:0]});
    check(resHi == exp[127:64] && hiDst == dst + 5'd1, "R4", "high half and tag",
          {59'd0, hiDst, resHi}, {59'd0, 5'(dst + 5'd1), exp[127:64]});
    for (int k = 0; k < holdCycles; k++) begin
      @(negedge clk);
      check(outValid && resLo == lo && resHi == hi && loDst == dst && !inReady, "R7",
            "hold while stalled", {resHi, resLo}, {hi, lo});
    end
    inValid = 1'b0;
    outReady = 1'b1;
    @(negedge clk);
    outReady = 1'b0;
    check(!outValid && inReady, "R8", "release", {126'd0, outValid, inReady}, 128'd1);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] lo, hi;
    logic [255:0] bigX;
    logic [63:0] scal, carry;
    logic [319:0] refProd, gotProd;

    // R9: reset state
    repeat (2) @(negedge clk);
    check(inReady && !outValid, "R9", "in reset", {126'd0, inReady, outValid}, 128'd2);
    rst_n = 1'b1;
    @(negedge clk);
    check(inReady && !outValid, "R9", "after reset", {126'd0, inReady, outValid}, 128'd2);

    // Table walk: R1, R3, R4, R8, R10
    for (int i = 0; i < NVEC; i++) begin
      doOp(TAB_A[i], TAB_B[i], TAB_C[i], TAB_D[i], i % 3, 1'b0, lo, hi);
    end

    // R2: all-ones corner, zero-extended addend
    doOp(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 5'd4, 0, 1'b0, lo, hi);
    check(hi == 64'hFFFF_FFFF_FFFF_FFFF && lo == 64'd0, "R2", "max operands", {hi, lo},
          {64'hFFFF_FFFF_FFFF_FFFF, 64'd0});
    doOp(64'd0, 64'd5, 64'h8000_0000_0000_0000, 5'd8, 0, 1'b0, lo, hi);
    check(hi == 64'd0 && lo == 64'h8000_0000_0000_0000, "R2", "unsigned addend", {hi, lo},
          {64'd0, 64'h8000_0000_0000_0000});

    // R4: index wrap
    doOp(64'd2, 64'd3, 64'd0, 5'd31, 0, 1'b0, lo, hi);

    // R6: inValid held high through a busy period, long stall for R7
    doOp(64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, 64'd9, 5'd12, 5, 1'b1, lo, hi);

    // R5: non-matching opcode consumed and dropped
    @(negedge clk);
    opSel = 6'b110011; opA = 64'd7; opB = 64'd7; opC = 64'd7; dstIdx = 5'd3; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check(inReady && !outValid, "R5", "bad opcode dropped", {126'd0, inReady, outValid}, 128'd2);
    for (int k = 0; k < NUM_STEPS + 2; k++) begin
      @(negedge clk);
      check(!outValid && inReady, "R5", "no result for bad opcode", 128'(outValid), 128'd0);
    end

    // R1: chained multi-limb product, high half fed back as addend
    bigX = 256'hF00D_CAFE_1234_5678_9ABC_DEF0_0FED_CBA9_FFFF_FFFF_FFFF_FFFF_8765_4321_0000_0001;
    scal = 64'hFEDC_BA98_7654_3211;
    refProd = {64'd0, bigX} * {256'd0, scal};
    carry = 64'd0;
    gotProd = '0;
    for (int i = 0; i < 4; i++) begin
      doOp(bigX[i*64 +: 64], scal, carry, 5'(2 * i), 0, 1'b0, lo, hi);
      gotProd[i*64 +: 64] = lo;
      carry = hi;
    end
    gotProd[319:256] = carry;
    check(gotProd == refProd, "R1", "chained product low", gotProd[127:0], refProd[127:0]);
    check(gotProd[319:128] == refProd[319:128], "R1", "chained product high",
          gotProd[255:128], refProd[255:128]);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule